// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffers

This block is a prefetch unit that sits behind a cache, between its miss path and memory. It holds several small circular stream buffers. Each buffer tracks one sequential run of line addresses. When the cache reports a miss, the block compares the miss line address against the oldest (head) entry of every active buffer. If a head matches, its line goes back to the cache and that buffer requests one more line to stay ahead of the stream. If no head matches, the block answers with a no-hit response. It then takes the least recently used buffer, clears it, and starts that buffer fetching the lines after the missed one.

The cache presents one miss at a time on a valid/ready port and gets exactly one response for it. A hit response carries the line data. A no-hit response tells the cache to fetch the line through its own path. Memory requests carry a tag that the memory echoes with its data, so responses may come back in any order. The tag records the buffer, the slot and a flush generation. A response whose generation no longer matches its buffer is dropped, because that buffer has been restarted since the request was sent.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, miss_ready_o is 1, resp_valid_o is 0 and mem_req_valid_o is 0.
- R2: A miss whose line address matches no buffer head gets one response with resp_hit_o=0. The chosen buffer then requests lines addr+1, addr+2, ..., addr+DEPTH, in that order.
- R3: A miss that matches a buffer head gets one response with resp_hit_o=1, resp_addr_o equal to the miss address, and resp_data_o equal to the data memory returned for that line.
- R4: Each head hit makes the hit buffer issue exactly one further request, for line hit address + DEPTH. Later heads of that buffer follow on sequentially.
- R5: Only head entries are compared. A miss equal to an address held deeper in a buffer gets resp_hit_o=0, and the buffer holding it keeps its stream.
- R6: On a head match whose data has not arrived, the response is held back until the data arrives. It then carries that data.
- R7: Several buffers track separate interleaved sequential streams. Alternating misses across the streams all hit after the first miss of each stream.
- R8: On a no-hit miss, the buffer whose last allocation or hit is oldest is the one reused. After reset, buffer NUM_BUF-1 is reused first and buffer 0 last.
- R9: A memory response whose tag belongs to a buffer that has been reallocated since the request was sent does not fill any entry. A later head hit in that buffer returns the data for its new address.
- R10: While a miss awaits its response, miss_ready_o is 0. Each accepted miss produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Cache miss request valid |
| miss_ready_o | output | 1 | Block can accept a miss |
| miss_addr_i | input | ADDR_W | Missing line address |
| resp_valid_o | output | 1 | Response for the outstanding miss |
| resp_hit_o | output | 1 | 1: line supplied from a buffer head; 0: not held |
| resp_addr_o | output | ADDR_W | Line address the response refers to |
| resp_data_o | output | DATA_W | Line data on a hit, zero otherwise |
| mem_req_valid_o | output | 1 | Prefetch request to memory |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Line address to fetch |
| mem_req_tag_o | output | TAG_W | Opaque tag, echoed by memory |
| mem_rsp_valid_i | input | 1 | Memory returns a line |
| mem_rsp_tag_i | input | TAG_W | Tag of the returned line |
| mem_rsp_data_i | input | DATA_W | Returned line data |

## Verification
Faulty buffer state shows up at the ports in one of three ways. A wrong head address appears as a wrong hit or no-hit decision on the next miss to that stream. A slot filled from a stale or misrouted response appears as wrong resp_data_o, often before the correct line arrives. A broken refill pointer shows in the order of mem_req_addr_o, in the cycles after an allocation or hit. Victim choice errors appear only after several allocations, as a surviving stream that misses or a dropped stream that still hits. The bench therefore compares every response against a queue of expected results and logs every request address. It includes sequences timed so that stale responses arrive before the fresh ones.

// File: rtl/sb_pkg.sv
package sb_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int N = 4,
  localparam int IDX_W = sb_pkg::idx_w(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age_q[i] == IDX_W'(N - 1));
      if (oldest[i]) victim_o = IDX_W'(i);
    end
  end

  // R8
  victim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot(oldest));
endmodule

// File: rtl/sb_buffer.sv
module sb_buffer #(
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int EPOCH_W = 3,
  localparam int SLOT_W = sb_pkg::idx_w(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [ADDR_W-1:0]  alloc_addr_i,
  input  logic               adv_i,
  input  logic               issue_i,
  input  logic               rsp_valid_i,
  input  logic [SLOT_W-1:0]  rsp_slot_i,
  input  logic [EPOCH_W-1:0] rsp_epoch_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  head_addr_o,
  output logic [DATA_W-1:0]  head_data_o,
  output logic               head_avail_o,
  output logic [EPOCH_W-1:0] epoch_o,
  output logic               pend_o,
  output logic [SLOT_W-1:0]  pend_slot_o,
  output logic [ADDR_W-1:0]  pend_addr_o
);
  logic [ADDR_W-1:0]  addr_q [DEPTH];
  logic [DATA_W-1:0]  data_q [DEPTH];
  logic [DEPTH-1:0]   avail_q, reqd_q;
  logic [SLOT_W-1:0]  head_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic               valid_q;

  function automatic logic [SLOT_W-1:0] slot_add(input logic [SLOT_W-1:0] s, input int k);
    int t;
    t = int'(s) + k;
    if (t >= DEPTH) t = t - DEPTH;
    return SLOT_W'(t);
  endfunction

  // oldest slot not yet sent to memory, searched from the head
  always_comb begin
    pend_o      = 1'b0;
    pend_slot_o = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (!pend_o && valid_q && !reqd_q[slot_add(head_q, k)]) begin
        pend_o      = 1'b1;
        pend_slot_o = slot_add(head_q, k);
      end
    end
  end

  assign pend_addr_o  = addr_q[pend_slot_o];
  assign valid_o      = valid_q;
  assign head_addr_o  = addr_q[head_q];
  assign head_data_o  = data_q[head_q];
  assign head_avail_o = avail_q[head_q];
  assign epoch_o      = epoch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
      avail_q <= '0;
      reqd_q  <= '0;
      head_q  <= '0;
      epoch_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (rsp_valid_i && rsp_epoch_i == epoch_q) begin
        data_q[rsp_slot_i]  <= rsp_data_i;
        avail_q[rsp_slot_i] <= 1'b1;
      end
      if (issue_i) reqd_q[pend_slot_o] <= 1'b1;
      if (adv_i) begin
        addr_q[head_q]  <= addr_q[head_q] + ADDR_W'(DEPTH);
        avail_q[head_q] <= 1'b0;
        reqd_q[head_q]  <= 1'b0;
        head_q          <= slot_add(head_q, 1);
      end
      if (alloc_i) begin
        for (int i = 0; i < DEPTH; i++) addr_q[i] <= alloc_addr_i + ADDR_W'(i + 1);
        avail_q <= '0;
        reqd_q  <= '0;
        head_q  <= '0;
        epoch_q <= epoch_q + 1'b1;
        valid_q <= 1'b1;
      end
    end
  end

  // R2
  alloc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (head_addr_o == $past(alloc_addr_i) + ADDR_W'(1)) && !head_avail_o);
  // R4
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !alloc_i) |=> head_addr_o == $past(head_addr_o) + ADDR_W'(1));
  // R6
  adv_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (head_avail_o && valid_o));
  // R9
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_epoch_i != epoch_q && !alloc_i && !adv_i) |=> $stable(avail_q));
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int EPOCH_W = 3,
  localparam int BUF_W  = sb_pkg::idx_w(NUM_BUF),
  localparam int SLOT_W = sb_pkg::idx_w(DEPTH),
  localparam int TAG_W  = EPOCH_W + BUF_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [TAG_W-1:0]  mem_req_tag_o,
  input  logic              mem_rsp_valid_i,
  input  logic [TAG_W-1:0]  mem_rsp_tag_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  logic [NUM_BUF-1:0] b_valid, b_avail, b_pend, b_alloc, b_adv, b_issue, b_rsp;
  logic [ADDR_W-1:0]  b_head_addr [NUM_BUF];
  logic [DATA_W-1:0]  b_head_data [NUM_BUF];
  logic [EPOCH_W-1:0] b_epoch     [NUM_BUF];
  logic [SLOT_W-1:0]  b_pend_slot [NUM_BUF];
  logic [ADDR_W-1:0]  b_pend_addr [NUM_BUF];

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              hit_any, req_any;
  logic [BUF_W-1:0]  hit_idx, req_idx, victim;
  logic [BUF_W-1:0]  rsp_buf;

  assign rsp_buf = mem_rsp_tag_i[SLOT_W +: BUF_W];

  // head match, lowest index wins
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (b_valid[b] && b_head_addr[b] == pend_addr_q) begin
        hit_any = 1'b1;
        hit_idx = BUF_W'(b);
      end
    end
  end

  assign miss_ready_o = !pend_q;
  assign resp_valid_o = pend_q && (!hit_any || b_avail[hit_idx]);
  assign resp_hit_o   = hit_any;
  assign resp_addr_o  = pend_addr_q;
  assign resp_data_o  = hit_any ? b_head_data[hit_idx] : '0;

  // request arbitration; a buffer being restarted does not issue this cycle
  always_comb begin
    req_any = 1'b0;
    req_idx = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (b_pend[b] && !b_alloc[b]) begin
        req_any = 1'b1;
        req_idx = BUF_W'(b);
      end
    end
  end

  assign mem_req_valid_o = req_any;
  assign mem_req_addr_o  = b_pend_addr[req_idx];
  assign mem_req_tag_o   = {b_epoch[req_idx], req_idx, b_pend_slot[req_idx]};

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      b_alloc[b] = resp_valid_o && !hit_any && victim == BUF_W'(b);
      b_adv[b]   = resp_valid_o && hit_any && hit_idx == BUF_W'(b);
      b_issue[b] = req_any && mem_req_ready_i && req_idx == BUF_W'(b);
      b_rsp[b]   = mem_rsp_valid_i && rsp_buf == BUF_W'(b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (miss_valid_i && miss_ready_o) begin
      pend_q      <= 1'b1;
      pend_addr_q <= miss_addr_i;
    end else if (resp_valid_o) begin
      pend_q <= 1'b0;
    end
  end

  sb_lru #(.N(NUM_BUF)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (resp_valid_o),
    .touch_idx_i (hit_any ? hit_idx : victim),
    .victim_o    (victim)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    sb_buffer #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W)
    ) i_buf (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (b_alloc[g]),
      .alloc_addr_i (pend_addr_q),
      .adv_i        (b_adv[g]),
      .issue_i      (b_issue[g]),
      .rsp_valid_i  (b_rsp[g]),
      .rsp_slot_i   (mem_rsp_tag_i[SLOT_W-1:0]),
      .rsp_epoch_i  (mem_rsp_tag_i[TAG_W-1 -: EPOCH_W]),
      .rsp_data_i   (mem_rsp_data_i),
      .valid_o      (b_valid[g]),
      .head_addr_o  (b_head_addr[g]),
      .head_data_o  (b_head_data[g]),
      .head_avail_o (b_avail[g]),
      .epoch_o      (b_epoch[g]),
      .pend_o       (b_pend[g]),
      .pend_slot_o  (b_pend_slot[g]),
      .pend_addr_o  (b_pend_addr[g])
    );
  end

  // R10
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> !miss_ready_o);
endmodule

// File: tb/test_stream_prefetch.sv
module test_stream_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 3 + 2 + 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              miss_valid_i = 1'b0;
  logic              miss_ready_o;
  logic [ADDR_W-1:0] miss_addr_i = '0;
  logic              resp_valid_o, resp_hit_o;
  logic [ADDR_W-1:0] resp_addr_o;
  logic [DATA_W-1:0] resp_data_o;
  logic              mem_req_valid_o;
  logic              mem_req_ready_i = 1'b1;
  logic [ADDR_W-1:0] mem_req_addr_o;
  logic [TAG_W-1:0]  mem_req_tag_o;
  logic              mem_rsp_valid_i = 1'b0;
  logic [TAG_W-1:0]  mem_rsp_tag_i = '0;
  logic [DATA_W-1:0] mem_rsp_data_i = '0;

  stream_prefetch i_stream_prefetch (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_ready_o(miss_ready_o), .miss_addr_i(miss_addr_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_addr_o(resp_addr_o),
    .resp_data_o(resp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_tag_o(mem_req_tag_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_tag_i(mem_rsp_tag_i),
    .mem_rsp_data_i(mem_rsp_data_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { logic [ADDR_W-1:0] a; logic hit; logic [DATA_W-1:0] d; string req; } exp_t;
  typedef struct { logic [ADDR_W-1:0] a; logic [TAG_W-1:0] t; int due; } mreq_t;

  exp_t              exp_q[$];
  mreq_t             mem_q[$];
  logic [ADDR_W-1:0] req_log[$];
  int errors = 0, checks = 0, cyc = 0, last_resp_cyc = 0;
  int mem_lat = 4;
  bit throttle = 1'b0;
  bit done = 1'b0;

  function automatic logic [DATA_W-1:0] line_data(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5a5a, a + 16'h0f0f};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: fixed latency, in order, optional request throttling
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst_ni) begin
        mem_q.delete();
        mem_rsp_valid_i = 1'b0;
      end else begin
        mem_req_ready_i = throttle ? cyc[0] : 1'b1;
        if (mem_req_valid_o && mem_req_ready_i) begin
          mem_q.push_back('{a: mem_req_addr_o, t: mem_req_tag_o, due: cyc + mem_lat});
          req_log.push_back(mem_req_addr_o);
        end
        if (mem_q.size() != 0 && mem_q[0].due <= cyc) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_tag_i   = mem_q[0].t;
          mem_rsp_data_i  = line_data(mem_q[0].a);
          void'(mem_q.pop_front());
        end else begin
          mem_rsp_valid_i = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && resp_valid_o) begin
      last_resp_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected response", int'(resp_addr_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(resp_addr_o == e.a, e.req, "resp addr", int'(resp_addr_o), int'(e.a));
        check(resp_hit_o == e.hit, e.req, "resp hit", int'(resp_hit_o), int'(e.hit));
        if (e.hit) check(resp_data_o == e.d, e.req, "resp data", int'(resp_data_o), int'(e.d));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    miss_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    req_log.delete();
    exp_q.delete();
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_miss(input logic [ADDR_W-1:0] a, input logic hit, input string req);
    @(negedge clk);
    while (!miss_ready_o) @(negedge clk);
    exp_q.push_back('{a: a, hit: hit, d: hit ? line_data(a) : '0, req: req});
    miss_valid_i = 1'b1;
    miss_addr_i  = a;
    @(negedge clk);
    miss_valid_i = 1'b0;
    // R10: busy right after acceptance
    check(!miss_ready_o, "R10", "ready after accept", int'(miss_ready_o), 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(miss_ready_o == 1'b1, "R1", "miss_ready", int'(miss_ready_o), 1);
    check(resp_valid_o == 1'b0, "R1", "resp_valid", int'(resp_valid_o), 0);
    check(mem_req_valid_o == 1'b0, "R1", "mem_req_valid", int'(mem_req_valid_o), 0);
    do_reset();

    // R2 allocation and sequential fetch
    do_miss(16'h0100, 1'b0, "R2");
    idle(12);
    check(req_log.size() == 4, "R2", "request count", req_log.size(), 4);
    for (int i = 0; i < 4 && i < req_log.size(); i++)
      check(req_log[i] == 16'h0101 + i, "R2", "request addr", int'(req_log[i]), 16'h0101 + i);

    // R3 / R4 head hits run ahead by one line each
    do_miss(16'h0101, 1'b1, "R3");
    do_miss(16'h0102, 1'b1, "R3");
    do_miss(16'h0103, 1'b1, "R4");
    idle(12);
    check(req_log.size() == 7, "R4", "request count", req_log.size(), 7);
    for (int i = 4; i < 7 && i < req_log.size(); i++)
      check(req_log[i] == 16'h0101 + i, "R4", "refill addr", int'(req_log[i]), 16'h0101 + i);

    // R5 deeper entry not looked up; owning stream kept
    do_miss(16'h0106, 1'b0, "R5");
    do_miss(16'h0104, 1'b1, "R5");
    do_miss(16'h0105, 1'b1, "R5");

    // R6 stall on head without data
    do_reset();
    mem_lat = 12;
    do_miss(16'h0800, 1'b0, "R6");
    t0 = cyc;
    do_miss(16'h0801, 1'b1, "R6");
    check(last_resp_cyc - t0 >= 8, "R6", "stall cycles", last_resp_cyc - t0, 8);
    do_miss(16'h0802, 1'b1, "R6");

    // R7 interleaved streams, throttled memory
    do_reset();
    mem_lat = 4;
    throttle = 1'b1;
    do_miss(16'h0200, 1'b0, "R7");
    do_miss(16'h0300, 1'b0, "R7");
    do_miss(16'h0400, 1'b0, "R7");
    do_miss(16'h0201, 1'b1, "R7");
    do_miss(16'h0301, 1'b1, "R7");
    do_miss(16'h0401, 1'b1, "R7");
    do_miss(16'h0202, 1'b1, "R7");
    do_miss(16'h0302, 1'b1, "R7");
    do_miss(16'h0402, 1'b1, "R7");
    do_miss(16'h0203, 1'b1, "R7");
    throttle = 1'b0;

    // R8 least recently hit buffer is reused
    do_miss(16'h0500, 1'b0, "R8");
    do_miss(16'h0600, 1'b0, "R8");
    do_miss(16'h0403, 1'b1, "R8");
    do_miss(16'h0204, 1'b1, "R8");
    do_miss(16'h0303, 1'b0, "R8");
    do_miss(16'h0601, 1'b1, "R8");

    // R9 stale responses after a flush are dropped
    do_reset();
    mem_lat = 40;
    do_miss(16'h0700, 1'b0, "R9");
    do_miss(16'h0900, 1'b0, "R9");
    do_miss(16'h0a00, 1'b0, "R9");
    do_miss(16'h0b00, 1'b0, "R9");
    do_miss(16'h0c00, 1'b0, "R9");
    do_miss(16'h0c01, 1'b1, "R9");
    do_miss(16'h0c02, 1'b1, "R9");
    do_miss(16'h0701, 1'b0, "R9");
    idle(20);
    check(exp_q.size() == 0, "R10", "pending responses", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule